// File: doc/BRIEF.md
# Bank-Switched Register Window

A byte-addressed window of 128 locations sits behind a plain parallel bus with a 7-bit address, 8-bit write and read data, a write strobe and a read strobe. The bottom of the window holds a block of fourteen clock/calendar storage bytes, followed by a general user-RAM area. The top 64 addresses form a switched region. With the bank-select bit clear, these addresses reach 64 more bytes of user RAM. With the bit set, they reach an extended register bank instead. That bank carries a read-only 64-bit identifier, and every other location in it is reserved.

The bank-select bit sits inside the window itself, in a control register in the clock area. Software flips banks with an ordinary write. The lower map looks the same in both banks, so existing code that touches only the clock and low-RAM areas keeps working whichever bank is selected. The clock bytes here are plain storage. No timekeeping is done.

Top module: `bankwin_top`

## Requirements
- R1: After a synchronous reset every clock byte and every RAM byte reads 0, and bank 0 is selected.
- R2: While `rd_en` is low, `rdata` is 0.
- R3: Addresses 00h–0Dh are read/write storage bytes. A write lands on the rising edge at which `wr_en` is high. A read returns the stored value in the same cycle as `rd_en`, so a read and write in the same cycle return the old value.
- R4: The control byte at 0Ah is fully readable and writable. Its bit 4 selects the bank: 0 selects extra RAM and 1 selects the extended bank.
- R5: Addresses 0Eh–3Fh are 50 bytes of user RAM that behave identically in both banks.
- R6: In bank 0, addresses 40h–7Fh are 64 read/write RAM bytes, for 114 user bytes in total.
- R7: In bank 1, address 40h+k (k = 0..7) reads byte k of the identifier, bits [8k+7:8k] of `ID_VALUE`. Writes there are discarded.
- R8: In bank 1, addresses 48h–7Fh read 0 and ignore writes. Those writes do not reach the bank-0 RAM.
- R9: Bank-0 extra RAM keeps its contents while bank 1 is selected, and reads back unchanged after bank 0 is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational, 0 when idle |

## Verification
The same switched addresses are written and read under both bank settings. This separates true aliasing from a decoder that ignores the bank bit. Writes aimed at identifier bytes and reserved bytes are followed by reads in both banks. This shows the writes neither stick in bank 1 nor leak into the bank-0 RAM. Other patterns cover the edges of each area (0Dh/0Eh, 3Fh/40h, 47h/48h, 7Fh), a control value with every bit set except the bank bit, a read and write in the same cycle, and a reset taken after the memory holds data.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int CLK_CNT   = 14;
    localparam int LRAM_BASE = 14;
    localparam int LRAM_CNT  = 50;
    localparam int XWIN_BASE = 64;
    localparam int XWIN_CNT  = 64;
    localparam int ID_BYTES  = 8;
    localparam int CTRL_ADDR = 10;
    localparam int BANK_BIT  = 4;
    localparam int IDX_W     = 6;

    typedef enum logic [2:0] {
        RG_CLK,
        RG_LRAM,
        RG_XRAM,
        RG_ID,
        RG_RSVD
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] idx;
    } slot_t;

    function automatic slot_t map_addr(input logic [ADDR_W-1:0] a, input logic bank);
        slot_t s;
        int    ai;
        ai = int'(a);
        if (ai < LRAM_BASE) begin
            s.region = RG_CLK;
            s.idx    = IDX_W'(ai);
        end else if (ai < XWIN_BASE) begin
            s.region = RG_LRAM;
            s.idx    = IDX_W'(ai - LRAM_BASE);
        end else if (!bank) begin
            s.region = RG_XRAM;
            s.idx    = IDX_W'(ai - XWIN_BASE);
        end else if (ai < XWIN_BASE + ID_BYTES) begin
            s.region = RG_ID;
            s.idx    = IDX_W'(ai - XWIN_BASE);
        end else begin
            s.region = RG_RSVD;
            s.idx    = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/bankwin_decode.sv
module bankwin_decode
    import bankwin_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output slot_t             slot
);

    always_comb begin
        slot = map_addr(addr, bank);
    end

endmodule

// File: rtl/bankwin_store.sv
module bankwin_store #(
    parameter int DEPTH   = 16,
    parameter int DW      = 8,
    parameter int TAP_IDX = 0,
    localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] tap
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (int'(idx) < DEPTH)) begin
            mem[idx] <= wdata;
        end
    end

    always_comb begin
        rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;
    end

    assign tap = mem[TAP_IDX];

endmodule

// File: rtl/bankwin_idrom.sv
module bankwin_idrom
    import bankwin_pkg::*;
#(
    parameter logic [64-1:0] ID_VALUE = 64'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        idx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] id_q [ID_BYTES];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                id_q[g] <= ID_VALUE[g*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata = id_q[idx];

endmodule

// File: rtl/bankwin_top.sv
module bankwin_top
    import bankwin_pkg::*;
#(
    parameter logic [63:0] ID_VALUE = 64'hC3A5_1F2E_3D4C_5B72
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int CLK_IW  = $clog2(CLK_CNT);
    localparam int LRAM_IW = $clog2(LRAM_CNT);
    localparam int XRAM_IW = $clog2(XWIN_CNT);

    slot_t             slot;
    logic              bank;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] clk_rd, lram_rd, xram_rd, id_rd;
    logic [DATA_W-1:0] unused_tap_l, unused_tap_x;
    logic              unused_bits;

    assign bank = ctrl_q[BANK_BIT];
    assign unused_bits = ^{ctrl_q[DATA_W-1:BANK_BIT+1], ctrl_q[BANK_BIT-1:0],
                           slot.idx[IDX_W-1:CLK_IW]};

    bankwin_decode u_dec (
        .addr (addr),
        .bank (bank),
        .slot (slot)
    );

    bankwin_store #(.DEPTH(CLK_CNT), .DW(DATA_W), .TAP_IDX(CTRL_ADDR)) u_clk (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && slot.region == RG_CLK),
        .idx   (slot.idx[CLK_IW-1:0]),
        .wdata (wdata),
        .rdata (clk_rd),
        .tap   (ctrl_q)
    );

    bankwin_store #(.DEPTH(LRAM_CNT), .DW(DATA_W), .TAP_IDX(0)) u_lram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && slot.region == RG_LRAM),
        .idx   (slot.idx[LRAM_IW-1:0]),
        .wdata (wdata),
        .rdata (lram_rd),
        .tap   (unused_tap_l)
    );

    bankwin_store #(.DEPTH(XWIN_CNT), .DW(DATA_W), .TAP_IDX(0)) u_xram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && slot.region == RG_XRAM),
        .idx   (slot.idx[XRAM_IW-1:0]),
        .wdata (wdata),
        .rdata (xram_rd),
        .tap   (unused_tap_x)
    );

    bankwin_idrom #(.ID_VALUE(ID_VALUE)) u_id (
        .clk   (clk),
        .rst   (rst),
        .idx   (slot.idx[2:0]),
        .rdata (id_rd)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (slot.region)
                RG_CLK:  rdata = clk_rd;
                RG_LRAM: rdata = lram_rd;
                RG_XRAM: rdata = xram_rd;
                RG_ID:   rdata = id_rd;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk
    import bankwin_pkg::*;
#(
    parameter logic [63:0] ID_VALUE = 64'h0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata
);

    logic bank_m;
    logic live;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_m <= 1'b0;
            live   <= 1'b0;
        end else begin
            live <= 1'b1;
            if (wr_en && int'(addr) == CTRL_ADDR) begin
                bank_m <= wdata[BANK_BIT];
            end
        end
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);

    p_ctrl_lowmap_r3: assert property (@(posedge clk) disable iff (rst)
        (live && $past(wr_en) && rd_en && !wr_en && addr == $past(addr)
         && int'(addr) < XWIN_BASE) |-> rdata == $past(wdata));

    p_xram_rw_r6: assert property (@(posedge clk) disable iff (rst)
        (live && $past(wr_en) && rd_en && !wr_en && addr == $past(addr)
         && int'(addr) >= XWIN_BASE && !bank_m) |-> rdata == $past(wdata));

    p_id_bytes_r7: assert property (@(posedge clk) disable iff (rst)
        (live && rd_en && bank_m && int'(addr) >= XWIN_BASE
         && int'(addr) < XWIN_BASE + ID_BYTES)
        |-> rdata == ID_VALUE[(int'(addr) - XWIN_BASE)*DATA_W +: DATA_W]);

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bank_m && int'(addr) >= XWIN_BASE + ID_BYTES) |-> rdata == '0);

endmodule

bind bankwin_top bankwin_chk #(.ID_VALUE(ID_VALUE)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata)
);

// File: tb/bankwin_top_bench.sv
module bankwin_top_bench;

    localparam logic [63:0] ID = 64'h8877_6655_4433_2211;
    localparam int NV = 30;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [6:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic       chk;
        logic [3:0] req;
    } vec_t;

    // Walked in order; state carries between entries.
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 7'h05, 8'h3C, 8'h00, 1'b0, 4'd3},
        '{1'b0, 1'b1, 7'h05, 8'h00, 8'h3C, 1'b1, 4'd3},   // R3 clock byte
        '{1'b1, 1'b0, 7'h0D, 8'hD7, 8'h00, 1'b0, 4'd3},
        '{1'b0, 1'b1, 7'h0D, 8'h00, 8'hD7, 1'b1, 4'd3},   // R3 top clock byte
        '{1'b1, 1'b0, 7'h0E, 8'hA5, 8'h00, 1'b0, 4'd5},
        '{1'b0, 1'b1, 7'h0E, 8'h00, 8'hA5, 1'b1, 4'd5},   // R5 first user byte
        '{1'b1, 1'b0, 7'h3F, 8'h5A, 8'h00, 1'b0, 4'd5},
        '{1'b0, 1'b1, 7'h3F, 8'h00, 8'h5A, 1'b1, 4'd5},   // R5 last user byte
        '{1'b1, 1'b0, 7'h40, 8'h11, 8'h00, 1'b0, 4'd6},
        '{1'b0, 1'b1, 7'h40, 8'h00, 8'h11, 1'b1, 4'd6},   // R6 extra RAM low
        '{1'b1, 1'b0, 7'h7F, 8'h22, 8'h00, 1'b0, 4'd6},
        '{1'b0, 1'b1, 7'h7F, 8'h00, 8'h22, 1'b1, 4'd6},   // R6 extra RAM high
        '{1'b1, 1'b0, 7'h0A, 8'hEF, 8'h00, 1'b0, 4'd4},
        '{1'b0, 1'b1, 7'h40, 8'h00, 8'h11, 1'b1, 4'd4},   // R4 bit4 clear keeps bank 0
        '{1'b1, 1'b0, 7'h0A, 8'h10, 8'h00, 1'b0, 4'd4},
        '{1'b0, 1'b1, 7'h0A, 8'h00, 8'h10, 1'b1, 4'd4},   // R4 control readback
        '{1'b0, 1'b1, 7'h40, 8'h00, 8'h11, 1'b1, 4'd7},   // R7 ID byte 0
        '{1'b0, 1'b1, 7'h47, 8'h00, 8'h88, 1'b1, 4'd7},   // R7 ID byte 7
        '{1'b1, 1'b0, 7'h41, 8'hFF, 8'h00, 1'b0, 4'd7},
        '{1'b0, 1'b1, 7'h41, 8'h00, 8'h22, 1'b1, 4'd7},   // R7 write discarded
        '{1'b0, 1'b1, 7'h48, 8'h00, 8'h00, 1'b1, 4'd8},   // R8 first reserved
        '{1'b1, 1'b0, 7'h7F, 8'h99, 8'h00, 1'b0, 4'd8},
        '{1'b0, 1'b1, 7'h7F, 8'h00, 8'h00, 1'b1, 4'd8},   // R8 write ignored
        '{1'b0, 1'b1, 7'h0E, 8'h00, 8'hA5, 1'b1, 4'd5},   // R5 same in bank 1
        '{1'b1, 1'b0, 7'h0A, 8'h00, 8'h00, 1'b0, 4'd9},
        '{1'b0, 1'b1, 7'h40, 8'h00, 8'h11, 1'b1, 4'd9},   // R9 preserved
        '{1'b0, 1'b1, 7'h7F, 8'h00, 8'h22, 1'b1, 4'd9},   // R9 / R8 no leak
        '{1'b0, 1'b1, 7'h41, 8'h00, 8'h00, 1'b1, 4'd8},   // R8 ID write did not leak
        '{1'b1, 1'b0, 7'h20, 8'h77, 8'h00, 1'b0, 4'd2},
        '{1'b0, 1'b0, 7'h20, 8'h00, 8'h00, 1'b1, 4'd2}    // R2 idle read is 0
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rdata;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bankwin_top #(.ID_VALUE(ID)) u_bankwin_top (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    task automatic op(input logic wr, input logic rd, input logic [6:0] a,
                      input logic [7:0] d, input logic [7:0] e,
                      input logic chk, input int req);
        @(negedge clk);
        wr_en = wr;
        rd_en = rd;
        addr  = a;
        wdata = d;
        #1;
        if (chk) begin
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL R%0d addr %h: actual %h expected %h", req, a, rdata, e);
            end
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        op(1'b0, 1'b1, 7'h05, 8'h00, 8'h00, 1'b1, 1);
        op(1'b0, 1'b1, 7'h0A, 8'h00, 8'h00, 1'b1, 1);
        op(1'b0, 1'b1, 7'h40, 8'h00, 8'h00, 1'b1, 1);
        for (int i = 0; i < NV; i++) begin
            op(TBL[i].wr, TBL[i].rd, TBL[i].a, TBL[i].d, TBL[i].e, TBL[i].chk, int'(TBL[i].req));
        end
        // R3 read during write returns old value
        op(1'b1, 1'b1, 7'h20, 8'hC1, 8'h77, 1'b1, 3);
        op(1'b0, 1'b1, 7'h20, 8'h00, 8'hC1, 1'b1, 3);
        // R1 reset after data and bank 1 selected
        op(1'b1, 1'b0, 7'h0A, 8'h10, 8'h00, 1'b0, 1);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        op(1'b0, 1'b1, 7'h40, 8'h00, 8'h00, 1'b1, 1);  // R1 bank 0, RAM cleared
        op(1'b0, 1'b1, 7'h20, 8'h00, 8'h00, 1'b1, 1);
        op(1'b0, 1'b1, 7'h0A, 8'h00, 8'h00, 1'b1, 1);
        // R7 ID reloaded after reset
        op(1'b1, 1'b0, 7'h0A, 8'h10, 8'h00, 1'b0, 7);
        op(1'b0, 1'b1, 7'h43, 8'h00, 8'h44, 1'b1, 7);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule